// File: doc/BRIEF.md
# Genome-configured functional unit array

This block is a virtual reconfigurable datapath for image classification. An 8x8 image of 8-bit pixels enters on a wide input together with a launch strobe. A selector stage takes one pixel from each image row and hands the eight picks to the first of five columns of processing units. Each column has eight units. Every unit picks two operands from the outputs of the previous column and applies one of eight byte functions. The block reports only the output of the top unit in the last column, which a fitness scorer outside the block interprets.

The whole configuration lives in a 400-bit genome. The genome arrives as 16-bit words and is first gathered in a shadow register. A small loader state machine has three states: `LD_IDLE`, `LD_FILL` and `LD_ARMED`. The first word written in `LD_IDLE` moves it to `LD_FILL`. The twenty-fifth word moves it to `LD_ARMED`. From `LD_ARMED` it returns to `LD_IDLE` on the commit transition, which copies the shadow into the active genome. That transition happens in the first cycle in which no strobe is present and no vector is still inside the pipeline. A register follows the selector and each column, so one vector can be launched on every cycle.

Top module: `fua_array`

## Requirements
- R1: After reset the block drives `res_valid` low and emits nothing until a vector is launched.
- R2: A genome is 25 words written with `gen_we`, the first word taking bits 399:384. C1 sits at 399:392 and C2 at 391:384. The selector for image row r sits at bits 383-3r down to 381-3r. The unit in column c and row r has index k=8c+r and sits at bits 359-9k down to 351-9k. Within a unit field, the top 3 bits are the function code, the middle 3 bits pick operand A and the low 3 bits pick operand B.
- R3: A loaded genome becomes active only in a cycle with no strobe and no vector in flight. Vectors launched before that cycle are computed entirely with the previous genome.
- R4: Words written while a complete genome waits for its commit are ignored.
- R5: Pixel p occupies `px_image[8p+7:8p]`, with p = 8*row + column. The selector value s of image row r feeds pixel 8r+s to first-column row r.
- R6: Function 0 gives A+B clamped to 0xFF. Function 1 gives 0xFF when A > C2, else 0. Function 2 gives 0xFF when C1 < A < C2 with both bounds excluded, else 0.
- R7: Function 3 gives 0xFF when A > B, else 0. Function 4 gives A AND B. Function 5 gives A OR B.
- R8: Function 6 gives the 9-bit sum A+B shifted right by one. Function 7 gives A shifted right by one.
- R9: `res_valid` rises on the sixth rising edge counting the edge that samples `px_valid`, and back-to-back strobes give back-to-back results.
- R10: `res_data` carries the row-0 unit of the last column. Units drawing on any row of the previous column follow the genome fields exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_we | input | 1 | Genome word write strobe |
| gen_word | input | 16 | Genome word, first word most significant |
| px_valid | input | 1 | Launches one image vector |
| px_image | input | 512 | 64 pixels, pixel p at bits 8p+7:8p |
| res_valid | output | 1 | Result strobe |
| res_data | output | 8 | Top unit of the last column |

## Verification
Two things can land in the same cycle: a genome word write and a vector launch. Each cycle also decides whether the commit is allowed. The bench streams one vector per cycle while it writes all 25 words of a new genome followed by five extra words. This keeps the loader armed while vectors are in flight. Every streamed result must match the old genome. After the stream stops and the pipeline drains, results must match the new genome, and any of the extra words leaking into it would show up as a mismatch.

// File: rtl/fua_pkg.sv
package fua_pkg;
    localparam int unsigned ROWS     = 8;
    localparam int unsigned COLS     = 5;
    localparam int unsigned PIX_W    = 8;
    localparam int unsigned IMG_COLS = 8;
    localparam int unsigned LOAD_W   = 16;

    localparam int unsigned SEL_W       = $clog2(IMG_COLS);
    localparam int unsigned SRC_W       = $clog2(ROWS);
    localparam int unsigned FN_W        = 3;
    localparam int unsigned UNIT_W      = FN_W + 2 * SRC_W;
    localparam int unsigned COL_CFG_W   = ROWS * UNIT_W;
    localparam int unsigned BUS_W       = ROWS * PIX_W;
    localparam int unsigned IMG_BITS    = ROWS * IMG_COLS * PIX_W;
    localparam int unsigned GENOME_BITS = 2 * PIX_W + ROWS * SEL_W + COLS * COL_CFG_W;
    localparam int unsigned LOAD_WORDS  = GENOME_BITS / LOAD_W;
    localparam int unsigned CNT_W       = $clog2(LOAD_WORDS + 1);
    localparam int unsigned LATENCY     = COLS + 1;

    localparam int unsigned C1_TOP   = GENOME_BITS - 1;
    localparam int unsigned C2_TOP   = C1_TOP - PIX_W;
    localparam int unsigned SEL_TOP  = C2_TOP - PIX_W;
    localparam int unsigned UNIT_TOP = SEL_TOP - ROWS * SEL_W;

    typedef enum logic [FN_W-1:0] {
        FN_SATADD = 3'd0,
        FN_HITHR  = 3'd1,
        FN_WINDOW = 3'd2,
        FN_GT     = 3'd3,
        FN_AND    = 3'd4,
        FN_OR     = 3'd5,
        FN_AVG    = 3'd6,
        FN_HALF   = 3'd7
    } fua_fn_e;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_FILL  = 2'd1,
        LD_ARMED = 2'd2
    } ld_state_e;
endpackage

// File: rtl/fua_loader.sv
module fua_loader
    import fua_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   word_we,
    input  logic [LOAD_W-1:0]      word_in,
    input  logic                   pipe_quiet,
    output logic [GENOME_BITS-1:0] genome_act,
    output ld_state_e              state_q,
    output logic [CNT_W-1:0]       count_q
);
    ld_state_e              state_d;
    logic                   take_word;
    logic                   commit;
    logic [GENOME_BITS-1:0] shadow_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // next state and control outputs
    always_comb begin
        state_d   = state_q;
        take_word = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            LD_IDLE: begin
                if (word_we) begin
                    take_word = 1'b1;
                    state_d   = LD_FILL;
                end
            end
            LD_FILL: begin
                if (word_we) begin
                    take_word = 1'b1;
                    if (count_q == CNT_W'(LOAD_WORDS - 1)) state_d = LD_ARMED;
                end
            end
            LD_ARMED: begin
                if (pipe_quiet) begin
                    commit  = 1'b1;
                    state_d = LD_IDLE;
                end
            end
            default: state_d = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q    <= '0;
            shadow_q   <= '0;
            genome_act <= '0;
        end else begin
            if (commit)         count_q <= '0;
            else if (take_word) count_q <= count_q + 1'b1;
            if (take_word) shadow_q <= {shadow_q[GENOME_BITS-LOAD_W-1:0], word_in};
            if (commit)    genome_act <= shadow_q;
        end
    end
endmodule

// File: rtl/fua_unit.sv
module fua_unit
    import fua_pkg::*;
(
    input  logic [BUS_W-1:0]  prev_bus,
    input  logic [UNIT_W-1:0] cfg,
    input  logic [PIX_W-1:0]  c1,
    input  logic [PIX_W-1:0]  c2,
    output logic [PIX_W-1:0]  y
);
    logic [SRC_W-1:0] src_a, src_b;
    logic [PIX_W-1:0] op_a, op_b;
    logic [PIX_W:0]   sum_w;
    fua_fn_e          fn;

    assign fn    = fua_fn_e'(cfg[UNIT_W-1 -: FN_W]);
    assign src_a = cfg[2*SRC_W-1 -: SRC_W];
    assign src_b = cfg[SRC_W-1:0];
    assign op_a  = prev_bus[src_a*PIX_W +: PIX_W];
    assign op_b  = prev_bus[src_b*PIX_W +: PIX_W];
    assign sum_w = {1'b0, op_a} + {1'b0, op_b};

    always_comb begin
        unique case (fn)
            FN_SATADD: y = sum_w[PIX_W] ? '1 : sum_w[PIX_W-1:0];
            FN_HITHR:  y = (op_a > c2) ? '1 : '0;
            FN_WINDOW: y = ((op_a > c1) && (op_a < c2)) ? '1 : '0;
            FN_GT:     y = (op_a > op_b) ? '1 : '0;
            FN_AND:    y = op_a & op_b;
            FN_OR:     y = op_a | op_b;
            FN_AVG:    y = sum_w[PIX_W:1];
            FN_HALF:   y = op_a >> 1;
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/fua_column.sv
module fua_column
    import fua_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [BUS_W-1:0]     in_bus,
    input  logic [COL_CFG_W-1:0] cfg,
    input  logic [PIX_W-1:0]     c1,
    input  logic [PIX_W-1:0]     c2,
    output logic                 out_vld,
    output logic [BUS_W-1:0]     out_bus
);
    logic [BUS_W-1:0] unit_y;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        fua_unit u_unit (
            .prev_bus (in_bus),
            .cfg      (cfg[COL_CFG_W-1-r*UNIT_W -: UNIT_W]),
            .c1       (c1),
            .c2       (c2),
            .y        (unit_y[r*PIX_W +: PIX_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= in_vld;
        out_bus <= unit_y;
    end
endmodule

// File: rtl/fua_array.sv
module fua_array
    import fua_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gen_we,
    input  logic [LOAD_W-1:0]   gen_word,
    input  logic                px_valid,
    input  logic [IMG_BITS-1:0] px_image,
    output logic                res_valid,
    output logic [PIX_W-1:0]    res_data
);
    logic [GENOME_BITS-1:0] genome_act;
    ld_state_e              ld_state;
    logic [CNT_W-1:0]       ld_count;
    logic                   pipe_busy;
    logic                   pipe_quiet;
    logic [COLS:0]          stage_vld;
    logic [BUS_W-1:0]       stage_bus [0:COLS];
    logic [BUS_W-1:0]       picked;
    logic [PIX_W-1:0]       c1, c2;

    assign c1         = genome_act[C1_TOP -: PIX_W];
    assign c2         = genome_act[C2_TOP -: PIX_W];
    assign pipe_busy  = |stage_vld;
    assign pipe_quiet = !pipe_busy && !px_valid;

    fua_loader u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_we    (gen_we),
        .word_in    (gen_word),
        .pipe_quiet (pipe_quiet),
        .genome_act (genome_act),
        .state_q    (ld_state),
        .count_q    (ld_count)
    );

    // selector column: row r may only pick from pixels of image row r
    for (genvar r = 0; r < ROWS; r++) begin : g_sel
        logic [SEL_W-1:0] s;
        assign s = genome_act[SEL_TOP - r*SEL_W -: SEL_W];
        assign picked[r*PIX_W +: PIX_W] = px_image[(r*IMG_COLS + s)*PIX_W +: PIX_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_vld[0] <= 1'b0;
        else        stage_vld[0] <= px_valid;
        stage_bus[0] <= picked;
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        fua_column u_col (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (stage_vld[c]),
            .in_bus  (stage_bus[c]),
            .cfg     (genome_act[UNIT_TOP - c*COL_CFG_W -: COL_CFG_W]),
            .c1      (c1),
            .c2      (c2),
            .out_vld (stage_vld[c+1]),
            .out_bus (stage_bus[c+1])
        );
    end

    assign res_valid = stage_vld[COLS];
    assign res_data  = stage_bus[COLS][PIX_W-1:0];
endmodule

// File: rtl/fua_array_chk.sv
module fua_array_chk
    import fua_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   px_valid,
    input logic                   res_valid,
    input logic [PIX_W-1:0]       res_data,
    input logic [GENOME_BITS-1:0] genome_act,
    input logic                   pipe_busy,
    input ld_state_e              ld_state,
    input logic [CNT_W-1:0]       ld_count
);
    logic [LATENCY-1:0] launch_hist;

    always_ff @(posedge clk) begin
        if (!rst_n) launch_hist <= '0;
        else        launch_hist <= {launch_hist[LATENCY-2:0], px_valid};
    end

    a_r9_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == launch_hist[LATENCY-1]);

    a_r3_commit_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(genome_act) |-> (!$past(px_valid) && !$past(pipe_busy)));

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ld_count <= CNT_W'(LOAD_WORDS));

    a_r4_armed_full: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_state == LD_ARMED) |-> (ld_count == CNT_W'(LOAD_WORDS)));

    a_r4_armed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_state == LD_ARMED) |=> (ld_state == LD_IDLE || $stable(ld_count)));

    a_r10_known_result: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !$isunknown(res_data));
endmodule

bind fua_array fua_array_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .px_valid   (px_valid),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .genome_act (genome_act),
    .pipe_busy  (pipe_busy),
    .ld_state   (ld_state),
    .ld_count   (ld_count)
);

// File: tb/fua_array_tb.sv
module fua_array_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         gen_we;
    logic [15:0]  gen_word;
    logic         px_valid;
    logic [511:0] px_image;
    logic         res_valid;
    logic [7:0]   res_data;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        int         due;
        string      tag;
    } item_t;
    item_t sbq[$];

    logic [399:0] model_g;
    int g_c1, g_c2;
    int g_sel [8];
    int g_fn  [40];
    int g_ia  [40];
    int g_ib  [40];

    fua_array u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_we    (gen_we),
        .gen_word  (gen_word),
        .px_valid  (px_valid),
        .px_image  (px_image),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] bench_op(int f, logic [7:0] a, logic [7:0] b,
                                            logic [7:0] c1, logic [7:0] c2);
        int s;
        s = int'(a) + int'(b);
        case (f)
            0: return (s > 255) ? 8'hFF : 8'(s);
            1: return (a > c2) ? 8'hFF : 8'h00;
            2: return (a > c1 && a < c2) ? 8'hFF : 8'h00;
            3: return (a > b) ? 8'hFF : 8'h00;
            4: return a & b;
            5: return a | b;
            6: return 8'(s / 2);
            default: return 8'(a / 2);
        endcase
    endfunction

    // reference decode of the genome layout stated in R2 and R5
    function automatic logic [7:0] model_eval(logic [399:0] g, logic [511:0] img);
        logic [7:0] cur [8];
        logic [7:0] nxt [8];
        logic [8:0] fld;
        logic [2:0] s;
        for (int r = 0; r < 8; r++) begin
            s      = g[383 - 3*r -: 3];
            cur[r] = img[(r*8 + int'(s))*8 +: 8];
        end
        for (int c = 0; c < 5; c++) begin
            for (int r = 0; r < 8; r++) begin
                fld    = g[359 - 9*(c*8 + r) -: 9];
                nxt[r] = bench_op(int'(fld[8:6]), cur[fld[5:3]], cur[fld[2:0]],
                                  g[399:392], g[391:384]);
            end
            for (int r = 0; r < 8; r++) cur[r] = nxt[r];
        end
        return cur[0];
    endfunction

    function automatic logic [399:0] pack_g();
        logic [399:0] g;
        g[399:392] = 8'(g_c1);
        g[391:384] = 8'(g_c2);
        for (int r = 0; r < 8; r++) g[383 - 3*r -: 3] = 3'(g_sel[r]);
        for (int k = 0; k < 40; k++)
            g[359 - 9*k -: 9] = {3'(g_fn[k]), 3'(g_ia[k]), 3'(g_ib[k])};
        return g;
    endfunction

    function automatic logic [511:0] rand_img();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic fail_line(string tag, logic [7:0] act, logic [7:0] exp);
        n_bad++;
        $display("FAIL %s: got %02h expected %02h (cycle %0d)", tag, act, exp, cyc);
    endtask

    // monitor: pop and compare as results appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (res_valid) begin
                n_cmp++;
                if (sbq.size() == 0) begin
                    fail_line("R9 unexpected result", res_data, 8'h00);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    if (it.due != cyc)
                        fail_line({it.tag, " timing R9"}, 8'(cyc - it.due), 8'h00);
                    else if (res_data !== it.exp)
                        fail_line(it.tag, res_data, it.exp);
                end
            end else if (sbq.size() != 0 && sbq[0].due < cyc) begin
                n_cmp++;
                fail_line({sbq[0].tag, " missing R9"}, 8'h00, sbq[0].exp);
                void'(sbq.pop_front());
            end
        end
    end

    task automatic idle(int n);
        px_valid = 1'b0;
        gen_we   = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_vec(logic [511:0] img, string tag);
        item_t it;
        px_valid = 1'b1;
        px_image = img;
        it.exp = model_eval(model_g, img);
        it.due = cyc + 6;
        it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    task automatic load_genome(logic [399:0] g);
        for (int i = 0; i < 25; i++) begin
            gen_we   = 1'b1;
            gen_word = g[399 - 16*i -: 16];
            @(negedge clk);
        end
        idle(10);
        model_g = g;
    endtask

    // columns 0..3 pass row r through (AND of a row with itself)
    task automatic set_identity();
        g_c1 = 8'h40;
        g_c2 = 8'hA0;
        for (int r = 0; r < 8; r++) g_sel[r] = r;
        for (int k = 0; k < 40; k++) begin
            g_fn[k] = 4;
            g_ia[k] = k % 8;
            g_ib[k] = k % 8;
        end
    endtask

    function automatic logic [511:0] pair_img(logic [7:0] a, logic [7:0] b);
        logic [511:0] v;
        v = rand_img();
        v[9*8 +: 8]  = a;
        v[18*8 +: 8] = b;
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog expired: got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] pa [12];
        logic [7:0] pb [12];
        logic [399:0] g_old, g_new;
        string tg;
        pa = '{8'hF0, 8'h10, 8'h80, 8'hFF, 8'h00, 8'h81, 8'h40, 8'hA0, 8'h41, 8'h9F, 8'hA1, 8'h01};
        pb = '{8'h20, 8'h20, 8'h80, 8'hFF, 8'h00, 8'h7F, 8'h10, 8'h10, 8'h90, 8'hA0, 8'h05, 8'h02};

        rst_n = 1'b0; gen_we = 1'b0; gen_word = '0; px_valid = 1'b0; px_image = '0;
        model_g = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset
        begin
            logic seen;
            seen = 1'b0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (res_valid !== 1'b0) seen = 1'b1;
            end
            n_cmp++;
            if (seen) fail_line("R1 res_valid after reset", 8'h01, 8'h00);
        end

        // R6 R7 R8: each function on operand pairs including the bounds
        for (int f = 0; f < 8; f++) begin
            set_identity();
            g_fn[32] = f; g_ia[32] = 1; g_ib[32] = 2;
            load_genome(pack_g());
            tg = (f < 3) ? "R6" : (f < 6) ? "R7" : "R8";
            for (int p = 0; p < 12; p++)
                send_vec(pair_img(pa[p], pb[p]), $sformatf("%s fn%0d pair%0d", tg, f, p));
            idle(8);
        end

        // R5: each row selector picks from its own image row
        for (int r = 0; r < 8; r++) begin
            set_identity();
            for (int q = 0; q < 8; q++) g_sel[q] = (q * 3 + r) % 8;
            g_ia[32] = r; g_ib[32] = r;
            load_genome(pack_g());
            for (int v = 0; v < 4; v++)
                send_vec(rand_img(), $sformatf("R5 row%0d", r));
            idle(8);
        end

        // R2 R10 R9: random genomes, vectors back to back
        for (int t = 0; t < 6; t++) begin
            g_c1 = $urandom % 256; g_c2 = $urandom % 256;
            for (int r = 0; r < 8; r++) g_sel[r] = $urandom % 8;
            for (int k = 0; k < 40; k++) begin
                g_fn[k] = $urandom % 8; g_ia[k] = $urandom % 8; g_ib[k] = $urandom % 8;
            end
            load_genome(pack_g());
            for (int v = 0; v < 20; v++)
                send_vec(rand_img(), $sformatf("R2 R10 rnd%0d", t));
            idle(8);
        end

        // R3 R4: load while streaming, then extra words while armed
        g_old = model_g;
        set_identity();
        g_fn[32] = 5; g_ia[32] = 3; g_ib[32] = 6;
        g_fn[3]  = 7;
        g_new = pack_g();
        for (int i = 0; i < 30; i++) begin
            gen_we   = 1'b1;
            gen_word = (i < 25) ? g_new[399 - 16*i -: 16] : (16'hA5A5 ^ 16'(i));
            send_vec(rand_img(), "R3 old genome while loading");
        end
        gen_we = 1'b0;
        idle(10);
        model_g = g_new;
        for (int v = 0; v < 10; v++) send_vec(rand_img(), "R4 new genome after extra words");
        idle(10);
        if (g_old == g_new) $display("note: genomes equal");

        if (sbq.size() != 0) begin
            n_cmp++;
            fail_line("R9 results outstanding", 8'(sbq.size()), 8'h00);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule